// File: doc/BRIEF.md
# Interrupt Routing Controller

The block collects sixteen interrupt sources and steers each one to one of up to six CPU interrupt lines. Sources 0 to 4 come from external PCI interrupt pins. Each of these pins has its own polarity and its own choice of level or edge sensing. Sources 5 to 15 come from on-chip event inputs that run on the block's clock. A high cycle on one of these inputs records a sticky event.

Software reaches the block through a plain 32-bit register bus. The bus is addressed by word index, so the byte offset is four times `bus_word`. A write takes effect on the clock edge that samples `bus_we`. A read returns combinationally the word selected by `bus_word`.

Each source has a 4-bit nibble that holds an enable bit and a destination selector. Each CPU line has a master enable bit. Software can read, for every CPU line, a 16-bit vector of the enabled sources that are pending on that line. Latched events are cleared by writing ones to a clear register.

Top module: `irq_router`

## Requirements
- R1: After reset, every register reads 0 and every `cpu_irq_o` bit is low. This means all sources are disabled and routed to line 0, all lines are disabled, and all pins are active-high and edge-sensed.
- R2: Source s is configured by the nibble at bits 4×(s mod 8) of word 0 (sources 0–7) or word 1 (sources 8–15). Bits [2:0] of the nibble select the destination line and bit 3 enables the source. Both words read back what was written.
- R3: CPU line k has a 16-bit status in word 2+k/2, at bits [15:0] for even k and [31:16] for odd k. Bit s of that status is set only if source s is pending, enabled, and routed to line k. A source routed to a selector value of 6 or 7 appears in no status.
- R4: Word 5 holds the line enable for line k at bit 16+k and reads back written values. All of its other bits read 0.
- R5: `cpu_irq_o[k]` is a register. It is high one cycle after line k is enabled and its status is non-zero, and it is low whenever the line is disabled.
- R6: Word 7 holds a 2-bit field for pin p at bits [2p+1:2p]. Bit 2p set means the pin is active-low. Bit 2p+1 set means the pin is level-sensed, and clear means it is edge-sensed. The word reads back its ten bits.
- R7: For an edge-sensed pin, the pin passes through two synchronizing flops. A rise of the polarity-corrected signal then sets a sticky pending bit, visible in status three edges after the pin changes. The bit stays set after the pin deasserts.
- R8: For a level-sensed pin, pending follows the synchronized, polarity-corrected pin. A clear write leaves it pending while the pin is still asserted.
- R9: Word 6 is write-one-to-clear. A 1 in bit s clears the latched event of source s, 0 bits leave sources unchanged, and the word reads 0. A new event in the same cycle as its clear wins.
- R10: A high cycle on `evt_i[i]` sets the sticky pending bit of source 5+i. The bit is visible in status on the next cycle and holds until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 3 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word` |
| pci_pin_i | input | 5 | External PCI interrupt pins (sources 0–4) |
| evt_i | input | 11 | On-chip event inputs (sources 5–15) |
| cpu_irq_o | output | 6 | CPU interrupt lines |

## Verification
Some properties are checked by assertions on every cycle. These are:
- a latched event holds until it is cleared, and a clear without a new event empties it;
- a level-sensed pin's pending bit equals the pin value from two cycles earlier, corrected for polarity;
- no source shows up on two lines at once;
- a disabled line stays low;
- control words take the written value.

Other behaviour only the bench scenarios can show. This covers the exact three-edge synchronizer latency and the one-cycle output register. It also covers the status word layout, the handling of selector values that name no line, set-beats-clear, and consistent routing under random mixes of polarity, sensing mode, enables and clear masks.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int BUS_W    = 32;
  localparam int NIB_W    = 4;
  localparam int SRC_PER_WORD = BUS_W / NIB_W;

  // register word indices
  localparam logic [2:0] W_CTRL_LO = 3'd0;
  localparam logic [2:0] W_CTRL_HI = 3'd1;
  localparam logic [2:0] W_STAT_A  = 3'd2;
  localparam logic [2:0] W_STAT_B  = 3'd3;
  localparam logic [2:0] W_STAT_C  = 3'd4;
  localparam logic [2:0] W_LINE_EN = 3'd5;
  localparam logic [2:0] W_CLEAR   = 3'd6;
  localparam logic [2:0] W_PINCFG  = 3'd7;

  localparam int LINE_EN_LSB = 16;

  typedef struct packed {
    logic       en;
    logic [2:0] dest;
  } src_nib_t;

  // true when a source nibble steers an enabled source to line k
  function automatic logic routed_to(input src_nib_t nib, input logic [2:0] k);
    return nib.en && (nib.dest == k);
  endfunction

  // polarity-corrected pin: field bit 0 set means active-low
  function automatic logic pin_active(input logic raw, input logic [1:0] cfg);
    return raw ^ cfg[0];
  endfunction

  // level mode when field bit 1 is set
  function automatic logic pin_is_level(input logic [1:0] cfg);
    return cfg[1];
  endfunction

endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_PCI = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PCI-1:0]         pci_pin_i,
  input  logic [NUM_SRC-NUM_PCI-1:0] evt_i,
  input  logic [2*NUM_PCI-1:0]       pcfg_i,
  input  logic [NUM_SRC-1:0]         clr_i,
  output logic [NUM_SRC-1:0]         pend_o,
  output logic [NUM_SRC-1:0]         set_evt_o
);

  localparam int NUM_EVT = NUM_SRC - NUM_PCI;

  logic [NUM_SRC-1:0] sticky_q;
  logic [1:0]         age_q;   // cycles since reset, saturating (assertion aid)

  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // sticky event latch: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= set_evt_o | (sticky_q & ~clr_i);
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PCI; p++) begin : g_pin
      logic sync1_q, sync2_q, prev_q;
      logic act, lvl;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sync1_q <= 1'b0;
          sync2_q <= 1'b0;
          prev_q  <= 1'b0;
        end else begin
          sync1_q <= pci_pin_i[p];
          sync2_q <= sync1_q;
          prev_q  <= act;
        end
      end

      assign act          = pin_active(sync2_q, pcfg_i[2*p +: 2]);
      assign lvl          = pin_is_level(pcfg_i[2*p +: 2]);
      assign set_evt_o[p] = act & ~prev_q;
      assign pend_o[p]    = lvl ? act : sticky_q[p];

      // R8: level pending equals the pin two cycles back, polarity corrected
      p_level_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q[1] && lvl) |-> (pend_o[p] == ($past(pci_pin_i[p], 2) ^ pcfg_i[2*p])));
    end

    for (p = 0; p < NUM_EVT; p++) begin : g_evt
      assign set_evt_o[NUM_PCI+p] = evt_i[p];
      assign pend_o[NUM_PCI+p]    = sticky_q[NUM_PCI+p];
    end

    for (p = 0; p < NUM_SRC; p++) begin : g_chk
      // R7/R10: a latched event holds until cleared
      p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q[p] && !clr_i[p]) |=> sticky_q[p]);
      // R9: a clear without a fresh event empties the latch
      p_clear_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[p] && !set_evt_o[p]) |=> !sticky_q[p]);
    end
  endgenerate

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_OUT = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         pend_i,
  input  logic [NIB_W*NUM_SRC-1:0]   ctrl_i,
  input  logic [NUM_OUT-1:0]         line_en_i,
  output logic [NUM_OUT*NUM_SRC-1:0] status_o,
  output logic [NUM_OUT-1:0]         cpu_irq_o
);

  logic [NUM_SRC-1:0] hit [NUM_OUT];
  logic [NUM_OUT-1:0] col [NUM_SRC];
  logic [NUM_OUT-1:0] any_hit;

  genvar k, s;
  generate
    for (k = 0; k < NUM_OUT; k++) begin : g_line
      for (s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[k][s] = pend_i[s] & routed_to(src_nib_t'(ctrl_i[NIB_W*s +: NIB_W]), 3'(k));
        assign col[s][k] = hit[k][s];
      end
      assign any_hit[k] = |hit[k];
      assign status_o[k*NUM_SRC +: NUM_SRC] = hit[k];

      // R5: a disabled line is low on the next cycle
      p_line_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en_i[k] |=> !cpu_irq_o[k]);
      // R5: an enabled line with pending status is high on the next cycle
      p_line_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en_i[k] && any_hit[k]) |=> cpu_irq_o[k]);
    end

    for (s = 0; s < NUM_SRC; s++) begin : g_col
      // R3: a source is seen on at most one line
      p_one_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col[s]) <= 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq_o <= '0;
    else        cpu_irq_o <= line_en_i & any_hit;
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_PCI = 5,
  parameter int NUM_OUT = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 bus_word,
  input  logic                       bus_we,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [NUM_OUT*NUM_SRC-1:0] status_i,
  output logic [NIB_W*NUM_SRC-1:0]   ctrl_o,
  output logic [NUM_OUT-1:0]         line_en_o,
  output logic [2*NUM_PCI-1:0]       pcfg_o,
  output logic [NUM_SRC-1:0]         clr_o
);

  localparam int CTRL_W     = NIB_W * NUM_SRC;
  localparam int CTRL_WORDS = CTRL_W / BUS_W;
  localparam int HALF_W     = BUS_W / 2;

  logic [HALF_W-1:0] stat_half [8];

  genvar w;
  generate
    for (w = 0; w < CTRL_WORDS; w++) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n) ctrl_o[BUS_W*w +: BUS_W] <= '0;
        else if (bus_we && bus_word == 3'(w)) ctrl_o[BUS_W*w +: BUS_W] <= bus_wdata;
      end
      // R2: a control word write lands as written
      p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word == 3'(w)) |=> (ctrl_o[BUS_W*w +: BUS_W] == $past(bus_wdata)));
    end

    for (w = 0; w < 8; w++) begin : g_half
      if (w < NUM_OUT) begin : g_used
        assign stat_half[w] = HALF_W'(status_i[w*NUM_SRC +: NUM_SRC]);
      end else begin : g_none
        assign stat_half[w] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_en_o <= '0;
      pcfg_o    <= '0;
    end else if (bus_we) begin
      if (bus_word == W_LINE_EN) line_en_o <= bus_wdata[LINE_EN_LSB +: NUM_OUT];
      if (bus_word == W_PINCFG)  pcfg_o    <= bus_wdata[2*NUM_PCI-1:0];
    end
  end

  assign clr_o = (bus_we && bus_word == W_CLEAR) ? bus_wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    unique case (bus_word)
      W_CTRL_LO: bus_rdata = ctrl_o[BUS_W-1:0];
      W_CTRL_HI: bus_rdata = ctrl_o[2*BUS_W-1:BUS_W];
      W_STAT_A:  bus_rdata = {stat_half[1], stat_half[0]};
      W_STAT_B:  bus_rdata = {stat_half[3], stat_half[2]};
      W_STAT_C:  bus_rdata = {stat_half[5], stat_half[4]};
      W_LINE_EN: bus_rdata = {HALF_W'(line_en_o), {HALF_W{1'b0}}};
      W_CLEAR:   bus_rdata = '0;
      W_PINCFG:  bus_rdata = BUS_W'(pcfg_o);
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int NUM_PCI = 5,
  parameter int NUM_OUT = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 bus_word,
  input  logic                       bus_we,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_PCI-1:0]         pci_pin_i,
  input  logic [NUM_SRC-NUM_PCI-1:0] evt_i,
  output logic [NUM_OUT-1:0]         cpu_irq_o
);

  localparam int CTRL_W = NIB_W * NUM_SRC;

  logic [CTRL_W-1:0]          ctrl;
  logic [NUM_OUT-1:0]         line_en;
  logic [2*NUM_PCI-1:0]       pcfg;
  logic [NUM_SRC-1:0]         clr;
  logic [NUM_SRC-1:0]         pend;
  logic [NUM_SRC-1:0]         set_evt;
  logic [NUM_OUT*NUM_SRC-1:0] status;

  irq_regs #(.NUM_SRC(NUM_SRC), .NUM_PCI(NUM_PCI), .NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_i(status),
    .ctrl_o(ctrl), .line_en_o(line_en), .pcfg_o(pcfg), .clr_o(clr)
  );

  irq_src_cond #(.NUM_SRC(NUM_SRC), .NUM_PCI(NUM_PCI)) u_cond (
    .clk(clk), .rst_n(rst_n), .pci_pin_i(pci_pin_i), .evt_i(evt_i),
    .pcfg_i(pcfg), .clr_i(clr), .pend_o(pend), .set_evt_o(set_evt)
  );

  irq_route #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .ctrl_i(ctrl),
    .line_en_i(line_en), .status_o(status), .cpu_irq_o(cpu_irq_o)
  );

  // R9: a clear write reaches only the sources named by its ones
  p_clear_scope_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |-> (bus_we && bus_word == W_CLEAR));

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16, NPCI = 5, NOUT = 6, NEVT = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  bus_word = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  logic [NPCI-1:0] pins = '0;
  logic [NEVT-1:0] evts = '0;
  wire  [NOUT-1:0] cpu_irq;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pci_pin_i(pins),
    .evt_i(evts), .cpu_irq_o(cpu_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [63:0]     m_ctrl;
  logic [NOUT-1:0] m_oen;
  logic [9:0]      m_pcfg;
  logic [NSRC-1:0] m_pend;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk); bus_word = w; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk); bus_word = w; #1; d = bus_rdata;
  endtask

  function automatic logic [15:0] exp_stat(input int k);
    logic [15:0] v = '0;
    for (int s = 0; s < NSRC; s++)
      if (m_pend[s] && m_ctrl[4*s+3] && (m_ctrl[4*s +: 3] == 3'(k))) v[s] = 1'b1;
    return v;
  endfunction

  function automatic logic [NOUT-1:0] exp_irq();
    logic [NOUT-1:0] v;
    for (int k = 0; k < NOUT; k++) v[k] = m_oen[k] & (|exp_stat(k));
    return v;
  endfunction

  task automatic check_all(input string req);
    logic [31:0] d;
    for (int w = 0; w < 3; w++) begin
      rd(3'(2 + w), d);
      check(req, d, {exp_stat(2*w+1), exp_stat(2*w)});
    end
    check({req, " R5 line"}, 32'(cpu_irq), 32'(exp_irq()));
  endtask

  task automatic cfg(input logic [63:0] c, input logic [NOUT-1:0] o, input logic [9:0] p);
    m_ctrl = c; m_oen = o; m_pcfg = p;
    wr(3'd0, c[31:0]); wr(3'd1, c[63:32]);
    wr(3'd5, {10'd0, o, 16'd0}); wr(3'd7, {22'd0, p});
  endtask

  function automatic logic [NPCI-1:0] idle_pins();
    logic [NPCI-1:0] v;
    for (int p = 0; p < NPCI; p++) v[p] = m_pcfg[2*p];
    return v;
  endfunction

  task automatic settle();
    pins = idle_pins(); evts = '0;
    idle(5); wr(3'd6, 32'hFFFF); idle(2);
    m_pend = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NPCI-1:0] a;
    logic [NEVT-1:0] e;
    logic [15:0] m;
    void'($urandom(32'd4242));
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    for (int w = 0; w < 8; w++) begin rd(3'(w), d); check("R1 reset word", d, 32'h0); end
    check("R1 reset lines", 32'(cpu_irq), 32'h0);

    // R2 R4 R6 R9 readback
    cfg({$urandom, $urandom}, 6'($urandom), 10'($urandom));
    rd(3'd0, d); check("R2 ctrl lo", d, m_ctrl[31:0]);
    rd(3'd1, d); check("R2 ctrl hi", d, m_ctrl[63:32]);
    rd(3'd5, d); check("R4 line enable", d, {10'd0, m_oen, 16'd0});
    wr(3'd5, 32'hFFFF_FFFF); m_oen = '1;
    rd(3'd5, d); check("R4 unused bits", d, 32'h003F_0000);
    rd(3'd7, d); check("R6 pin cfg", d, {22'd0, m_pcfg});
    rd(3'd6, d); check("R9 clear reads 0", d, 32'h0);

    // R8 level pin 0, active-low, clear has no lasting effect
    cfg(64'h8, 6'h01, 10'b11); settle();
    check_all("R8 idle");
    pins[0] = 1'b0; idle(5); m_pend = 16'h1;
    check_all("R8 asserted");
    wr(3'd6, 32'h1); idle(2);
    check_all("R8 after clear");
    pins[0] = 1'b1; idle(5); m_pend = 16'h0;
    check_all("R8 released");

    // R7 edge latency on pin 1 (edge, active-high), routed to line 0
    cfg(64'h80, 6'h01, 10'b0); settle();
    bus_word = 3'd2;
    @(negedge clk); pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1 check("R7 not yet after two edges", 32'(bus_rdata[1]), 32'h0);
    @(negedge clk); #1 check("R7 set after three edges", 32'(bus_rdata[1]), 32'h1);
    pins[1] = 1'b0; idle(5); m_pend = 16'h2;
    check_all("R7 sticky after release");

    // R5 R10 output latency: event source 5 to line 2
    cfg(64'h00A0_0000, 6'h04, 10'b0); settle();
    @(negedge clk); evts[0] = 1'b1;
    @(negedge clk); evts[0] = 1'b0; #1
    check("R5 line not yet", 32'(cpu_irq[2]), 32'h0);
    bus_word = 3'd3; #1 check("R10 status next cycle", 32'(bus_rdata[5]), 32'h1);
    @(negedge clk); #1 check("R5 line one cycle later", 32'(cpu_irq[2]), 32'h1);
    m_pend = 16'h20;
    wr(3'd5, 32'h0); m_oen = '0; idle(1);
    check_all("R5 line disabled");

    // R9 set wins over clear in the same cycle (source 6 to line 0)
    cfg(64'h0800_0000, 6'h01, 10'b0); settle();
    @(negedge clk); evts[1] = 1'b1; bus_word = 3'd6; bus_we = 1'b1; bus_wdata = 32'h40;
    @(negedge clk); evts[1] = 1'b0; bus_we = 1'b0;
    m_pend = 16'h40;
    check_all("R9 set wins");

    // R3 selector 7 names no line; reroute to line 1 shows it
    cfg(64'h00F0_0000, 6'h3F, 10'b0); settle();
    @(negedge clk); evts[0] = 1'b1; @(negedge clk); evts[0] = 1'b0;
    m_pend = 16'h20; idle(2);
    for (int w = 0; w < 3; w++) begin rd(3'(2 + w), d); check("R3 dest 7 hidden", d, 32'h0); end
    check("R3 dest 7 no line", 32'(cpu_irq), 32'h0);
    m_ctrl[23:20] = 4'b1001; wr(3'd0, m_ctrl[31:0]); idle(1);
    check_all("R3 R2 rerouted");

    // random mixes of routing, polarity, sensing and clear masks
    for (int r = 0; r < 30; r++) begin
      cfg({$urandom, $urandom}, 6'($urandom), 10'($urandom));
      settle();
      check_all("R3 random idle");
      a = 5'($urandom); e = 11'($urandom);
      pins = idle_pins() ^ a;
      @(negedge clk); evts = e; @(negedge clk); evts = '0;
      idle(5); m_pend = {e, a};
      check_all("R6 R7 R10 random asserted");
      pins = idle_pins(); idle(5);
      for (int p = 0; p < NPCI; p++) if (m_pcfg[2*p+1]) m_pend[p] = 1'b0;
      check_all("R7 R8 random released");
      m = 16'($urandom);
      wr(3'd6, {16'd0, m}); idle(1);
      m_pend = m_pend & ~m;
      check_all("R9 random clear");
    end

    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule